// File: doc/BRIEF.md
# Reset Origin Sequencer

This block owns a shared, open-drain, active-low reset pin and works out whether a reset came from outside the chip or from an internal watchdog or clock-monitor fault. Any reset condition makes it pull the pin low for a fixed number of enabled bus cycles and then let go. A few enabled cycles later it looks at the pin again. If the pin is still low, something outside is holding it and the reset is external. If the pin is high, the chip itself raised the reset.

The pin level enters through a two-flop synchroniser. All sequence timing counts only clock cycles in which `bus_ce` is high. The internal system reset covers the whole sequence. For an external reset it also stays on until the pin is seen high again. After the sequence, a cause flag and a two-bit source code tell the vector logic which kind of reset happened.

Top module: `rst_origin_seq`

## Requirements
- R1: A reset condition in idle starts a sequence that drives `pin_pull` high for exactly DRIVE_CYC (default 8) enabled bus cycles. A reset condition is `wdog_req` high, `cmon_req` high, or the synchronised pin low.
- R2: The pin is sampled SAMPLE_GAP (default 4) enabled bus cycles after `pin_pull` drops. For an internal reset, `sys_rst` falls on that same edge.
- R3: If the sample is low, `cause_ext` becomes 1 and `cause_code` becomes 2'b00.
- R4: If the sample is high, `cause_ext` becomes 0 and `cause_code` holds the requests latched at the start of the sequence: bit 0 for watchdog, bit 1 for clock monitor, 2'b11 for both. A sequence started only by a brief pin pulse reports 2'b00.
- R5: A pin held low from outside for at least 16 bus cycles is classified as external.
- R6: `sys_rst` is high from the start of the sequence until classification. After an external classification it stays high until the synchronised pin is high, then it falls.
- R7: When a new sequence starts, `cause_ext` and `cause_code` clear to 0. They are otherwise held until the next sequence begins.
- R8: Requests that arrive while a sequence is running are ignored. They alter neither the cause code nor start a further sequence once the running one completes.
- R9: After `rst_n`, `pin_pull`, `sys_rst`, `cause_ext` and `cause_code` are all 0.
- R10: Cycles with `bus_ce` low do not advance the sequence. With `bus_ce` high one cycle in three, drive and gap take three times as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_ce | input | 1 | Bus-cycle enable; timing counts only these cycles |
| wdog_req | input | 1 | Watchdog timeout request |
| cmon_req | input | 1 | Clock monitor failure request |
| pin_in | input | 1 | Level seen on the reset pin |
| pin_pull | output | 1 | Pull-down enable for the reset pin |
| sys_rst | output | 1 | Internal system reset, active high |
| cause_ext | output | 1 | 1 when the last reset was external |
| cause_code | output | 2 | Internal source of the last reset |

## Verification
The hardest case to reach is a pin pulse from outside that ends while the block is still driving the pin. This pulse starts a sequence but is gone before the sample, so the block must report an internal reset with no source. The bench models the open-drain pin as the AND of the block's pull-down and an external holder. It releases the holder at chosen cycles: a 3-cycle pulse, exactly 16 cycles, and a long hold. This puts the release before, just after, and well past the sample point. It also injects a request in the middle of a drive to show that the request is dropped.

// File: rtl/rst_origin_seq.sv
module rst_origin_seq #(
  parameter int DRIVE_CYC   = 8,
  parameter int SAMPLE_GAP  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_ce,
  input  logic       wdog_req,
  input  logic       cmon_req,
  input  logic       pin_in,
  output logic       pin_pull,
  output logic       sys_rst,
  output logic       cause_ext,
  output logic [1:0] cause_code
);
  localparam int CMAX = (DRIVE_CYC > SAMPLE_GAP) ? DRIVE_CYC : SAMPLE_GAP;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DRV_LAST = CW'(DRIVE_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(SAMPLE_GAP - 1);

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_GAP, S_HOLD} st_t;

  st_t                  state;
  logic [CW-1:0]        cnt;
  logic [1:0]           src_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                 pin_s;
  logic                 start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign start    = (state == S_IDLE) && bus_ce && (wdog_req || cmon_req || !pin_s);
  assign pin_pull = (state == S_DRIVE);
  assign sys_rst  = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      src_q      <= 2'b00;
      cause_ext  <= 1'b0;
      cause_code <= 2'b00;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            state      <= S_DRIVE;
            cnt        <= '0;
            src_q      <= {cmon_req, wdog_req};
            cause_ext  <= 1'b0;
            cause_code <= 2'b00;
          end
        S_DRIVE:
          if (bus_ce) begin
            if (cnt == DRV_LAST) begin
              state <= S_GAP;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
        S_GAP:
          if (bus_ce) begin
            if (cnt == GAP_LAST) begin
              cnt <= '0;
              if (pin_s) begin
                state      <= S_IDLE;
                cause_ext  <= 1'b0;
                cause_code <= src_q;
              end else begin
                state      <= S_HOLD;
                cause_ext  <= 1'b1;
                cause_code <= 2'b00;
              end
            end else cnt <= cnt + 1'b1;
          end
        S_HOLD:
          if (bus_ce && pin_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] drv_ticks;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         drv_ticks <= '0;
    else if (!pin_pull) drv_ticks <= '0;
    else if (bus_ce)    drv_ticks <= drv_ticks + 1'b1;

  assert_drive_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_pull) |-> drv_ticks == CW'(DRIVE_CYC));

  assert_pull_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_pull) |-> !$past(sys_rst));

  assert_ext_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cause_ext |-> cause_code == 2'b00);

  assert_release_pin_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> pin_s);

  assert_cause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && !start) |=> $stable({cause_ext, cause_code}));

  assert_ignore_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !$past(!sys_rst)) |-> $stable(src_q));
endmodule

// File: tb/rst_origin_seq_tb.sv
module rst_origin_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce = 1'b1;
  logic wdog_req = 1'b0;
  logic cmon_req = 1'b0;
  logic ext_low = 1'b0;
  logic pin_in;
  logic pin_pull, sys_rst, cause_ext;
  logic [1:0] cause_code;
  logic slow_ce = 1'b0;
  int   div = 0;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  assign pin_in = !(pin_pull || ext_low);

  rst_origin_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .wdog_req(wdog_req),
    .cmon_req(cmon_req), .pin_in(pin_in), .pin_pull(pin_pull),
    .sys_rst(sys_rst), .cause_ext(cause_ext), .cause_code(cause_code)
  );

  always @(negedge clk) begin
    if (slow_ce) begin
      div = (div + 1) % 3;
      bus_ce = (div == 0);
    end else bus_ce = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pull(output int drv, output int gap);
    int guard = 0;
    drv = 0;
    gap = 0;
    while (!pin_pull && guard < 100) begin @(negedge clk); guard++; end
    while (pin_pull && guard < 400) begin drv++; @(negedge clk); guard++; end
    while (sys_rst && guard < 600) begin gap++; @(negedge clk); guard++; end
  endtask

  task automatic pulse_req(input bit w, input bit c);
    @(negedge clk);
    wdog_req = w;
    cmon_req = c;
    @(negedge clk);
    wdog_req = 1'b0;
    cmon_req = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 pin_pull", pin_pull, 0);
    check("R9 sys_rst", sys_rst, 0);
    check("R9 cause", {cause_ext, cause_code}, 0);
  endtask

  task automatic t_wdog();
    int d, g;
    fork pulse_req(1, 0); wait_pull(d, g); join
    check("R1 drive length", d, 8);
    check("R2 sample gap", g, 4);
    check("R4 ext flag", cause_ext, 0);
    check("R4 watchdog code", cause_code, 1);
  endtask

  task automatic t_cmon_clear();
    int d, g;
    @(negedge clk);
    cmon_req = 1'b1;
    @(negedge clk);
    cmon_req = 1'b0;
    check("R7 cleared at start", {cause_ext, cause_code}, 0);
    check("R6 sys_rst at start", sys_rst, 1);
    wait_pull(d, g);
    check("R4 clock monitor code", cause_code, 2);
  endtask

  task automatic t_both();
    int d, g;
    fork pulse_req(1, 1); wait_pull(d, g); join
    check("R4 both code", cause_code, 3);
  endtask

  task automatic t_short_pulse();
    int d, g;
    @(negedge clk);
    ext_low = 1'b1;
    repeat (3) @(negedge clk);
    ext_low = 1'b0;
    wait_pull(d, g);
    check("R4 short pulse drive", d, 8);
    check("R4 short pulse ext", cause_ext, 0);
    check("R4 short pulse code", cause_code, 0);
  endtask

  task automatic t_ext16();
    int n = 0;
    @(negedge clk);
    ext_low = 1'b1;
    repeat (16) @(negedge clk);
    ext_low = 1'b0;
    while (sys_rst && n < 50) begin @(negedge clk); n++; end
    check("R5 sixteen cycles ext", cause_ext, 1);
    check("R3 ext code", cause_code, 0);
  endtask

  task automatic t_ext_long();
    @(negedge clk);
    ext_low = 1'b1;
    repeat (40) @(negedge clk);
    check("R6 held during external", sys_rst, 1);
    check("R3 ext flag while held", cause_ext, 1);
    check("R1 no pull while held", pin_pull, 0);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 release after pin high", sys_rst, 0);
  endtask

  task automatic t_ignore();
    int n = 0;
    @(negedge clk);
    wdog_req = 1'b1;
    @(negedge clk);
    wdog_req = 1'b0;
    repeat (3) @(negedge clk);
    cmon_req = 1'b1;
    @(negedge clk);
    cmon_req = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 code unchanged", cause_code, 1);
    repeat (30) begin @(negedge clk); if (sys_rst) n++; end
    check("R8 no further sequence", n, 0);
  endtask

  task automatic t_slow_ce();
    int d, g;
    slow_ce = 1'b1;
    repeat (6) @(negedge clk);
    fork
      begin
        @(negedge clk);
        cmon_req = 1'b1;
        while (!sys_rst) @(negedge clk);
        cmon_req = 1'b0;
      end
      wait_pull(d, g);
    join
    check("R10 slow drive length", d, 24);
    check("R10 slow gap", g, 12);
    check("R10 slow code", cause_code, 2);
    slow_ce = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wdog();
    t_cmon_clear();
    t_both();
    t_short_pulse();
    t_ext16();
    t_ext_long();
    t_ignore();
    t_slow_ce();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule